// File: doc/BRIEF.md
# Split Carry-Save Coefficient Multiplier

This block multiplies the two unsigned 48-bit coefficients of a floating multiply and returns the full 96-bit product after a fixed number of cycles. The multiplier operand is cut into a lower and an upper 24-bit slice. Two independent reduction lanes work on the slices at the same time. Each lane keeps its running partial product in redundant sum/carry form and feeds it through a chain of 3:2 carry-save compressors. Every cycle, each lane retires a fixed group of multiplier bits.

Neither lane propagates a carry while it reduces. The long carry chain appears only once, in the merge cycle. In that cycle both redundant pairs are resolved, the upper lane is weighted by 2^24, and the two are added into the product register. The product register then drives the output during one separate store cycle, in which the result-valid strobe is raised.

The block is started with a one-cycle strobe while idle. It reports busy for the whole operation and keeps the last product on its output until the next result replaces it. Exponent arithmetic, normalization, rounding and special operands belong to other blocks.

Top module: `coefMul`

## Requirements
- R1: After reset, `busy` is 0, `resultValid` is 0 and `product` is 0.
- R2: A `start` sampled high at a rising edge while `busy` is 0 makes `busy` read 1 for exactly the ten cycles that follow that edge, and 0 after that.
- R3: `product` equals the unsigned 96-bit product `coefA * coefB` of the operands captured with `start`, for any operands, including zero, all-ones and single-bit values.
- R4: `resultValid` is 1 only in the tenth busy cycle of an operation, nine edges after the start edge, and never while `busy` is 0.
- R5: `resultValid` is a single-cycle pulse, one per operation.
- R6: A `start` that arrives while `busy` is 1 has no effect: the operation in progress keeps its timing and its operands, and no extra operation follows.
- R7: `product` holds its value from the valid cycle until the next operation's valid cycle.
- R8: Bits 23:0 of `coefB` form the lower lane and bits 47:24 the upper lane, which carries weight 2^24. A multiplier that has bits in only one lane still produces the exact product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle request to begin a multiply |
| coefA | input | 48 | Multiplicand coefficient, unsigned |
| coefB | input | 48 | Multiplier coefficient, unsigned |
| busy | output | 1 | High while an operation is in progress |
| resultValid | output | 1 | One-cycle strobe marking a new product |
| product | output | 96 | Unsigned product, held until the next result |

## Verification
A wrong carry or a lost bit in one reduction lane does not show up while the operation runs. It shows up only at the valid strobe, nine edges after start, as a product error. The error is confined to bits at or above the first faulty weight, and it is shifted by 24 when the fault is in the upper lane. Operands with bits in only one lane, or with all-ones patterns that exercise every compressor, therefore separate the two lanes. A sequencing fault shows at once in `busy` and `resultValid`: a pulse that is early, late or doubled, or busy held for the wrong length, is visible in the first operation.

// File: rtl/coefMulPkg.sv
package coefMulPkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;   // capture operands, clear redundant accumulators
    logic step;   // retire one bit group in each lane
    logic merge;  // resolve both lanes into the product register
  } mulStrobe_t;

endpackage

// File: rtl/csaLane.sv
// One reduction lane: a slice of the multiplier against the full multiplicand,
// accumulated in redundant sum/carry form through a chain of 3:2 compressors.
module csaLane
  import coefMulPkg::*;
#(
  parameter int MCAND_W = 48,
  parameter int SLICE_W = 24,
  parameter int GROUP   = 3,
  localparam int ACC_W  = MCAND_W + SLICE_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  mulStrobe_t         strb,
  input  logic [MCAND_W-1:0] mcandIn,
  input  logic [SLICE_W-1:0] mplierIn,
  output logic [ACC_W-1:0]   sumOut,
  output logic [ACC_W-1:0]   carryOut
);

  logic [ACC_W-1:0]   mcandSh;
  logic [SLICE_W-1:0] mplierSh;
  logic [ACC_W-1:0]   sumQ, carryQ;

  // Compressor chain: level 0 is the stored pair, each level folds in one row
  logic [ACC_W-1:0] lvlSum   [0:GROUP];
  logic [ACC_W-1:0] lvlCarry [0:GROUP];

  assign lvlSum[0]   = sumQ;
  assign lvlCarry[0] = carryQ;

  for (genvar j = 0; j < GROUP; j++) begin : g_row
    logic [ACC_W-1:0] ppRow;
    assign ppRow = mplierSh[j] ? (mcandSh << j) : '0;
    assign lvlSum[j+1]   = lvlSum[j] ^ lvlCarry[j] ^ ppRow;
    assign lvlCarry[j+1] = ((lvlSum[j] & lvlCarry[j]) |
                            (lvlSum[j] & ppRow)       |
                            (lvlCarry[j] & ppRow)) << 1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mcandSh  <= '0;
      mplierSh <= '0;
      sumQ     <= '0;
      carryQ   <= '0;
    end else if (strb.load) begin
      mcandSh  <= ACC_W'(mcandIn);
      mplierSh <= mplierIn;
      sumQ     <= '0;
      carryQ   <= '0;
    end else if (strb.step) begin
      sumQ     <= lvlSum[GROUP];
      carryQ   <= lvlCarry[GROUP];
      mcandSh  <= mcandSh << GROUP;
      mplierSh <= mplierSh >> GROUP;
    end
  end

  assign sumOut   = sumQ;
  assign carryOut = carryQ;

  // R8: once the slice has no bits left, a step must not change the lane's total
  p_spent_bits_inert_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && !strb.load && mplierSh == '0) |=>
      (sumQ + carryQ) == $past(sumQ + carryQ));

  // R3: a load clears the redundant pair
  p_load_clears_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (sumQ == '0 && carryQ == '0));

endmodule

// File: rtl/coefMulDatapath.sv
// Two reduction lanes and the final carry-propagate merge.
module coefMulDatapath
  import coefMulPkg::*;
#(
  parameter int COEF_W  = 48,
  parameter int LANES   = 2,
  parameter int GROUP   = 3,
  localparam int SLICE_W = COEF_W / LANES,
  localparam int ACC_W   = COEF_W + SLICE_W,
  localparam int PROD_W  = 2 * COEF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  mulStrobe_t        strb,
  input  logic [COEF_W-1:0] coefA,
  input  logic [COEF_W-1:0] coefB,
  output logic [PROD_W-1:0] productOut
);

  logic [ACC_W-1:0]  laneSum   [0:LANES-1];
  logic [ACC_W-1:0]  laneCarry [0:LANES-1];
  logic [PROD_W-1:0] laneWeighted [0:LANES-1];

  for (genvar h = 0; h < LANES; h++) begin : g_lane
    csaLane #(
      .MCAND_W(COEF_W),
      .SLICE_W(SLICE_W),
      .GROUP  (GROUP)
    ) u_lane (
      .clk     (clk),
      .rstN    (rstN),
      .strb    (strb),
      .mcandIn (coefA),
      .mplierIn(coefB[h*SLICE_W +: SLICE_W]),
      .sumOut  (laneSum[h]),
      .carryOut(laneCarry[h])
    );
    // Each lane's total fits in ACC_W bits; resolve it, then apply its slice weight
    logic [ACC_W-1:0] laneTotal;
    assign laneTotal       = laneSum[h] + laneCarry[h];
    assign laneWeighted[h] = PROD_W'(laneTotal) << (h * SLICE_W);
  end

  logic [PROD_W-1:0] mergeSum;
  always_comb begin
    mergeSum = '0;
    for (int h = 0; h < LANES; h++) mergeSum = mergeSum + laneWeighted[h];
  end

  logic [PROD_W-1:0] productQ;
  always_ff @(posedge clk) begin
    if (!rstN)           productQ <= '0;
    else if (strb.merge) productQ <= mergeSum;
  end

  assign productOut = productQ;

  // R7: the product register changes only on a merge
  p_product_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.merge |=> $stable(productQ));

endmodule

// File: rtl/coefMulCtrl.sv
// Sequencer: load, GROUP-bit steps, one merge cycle, one store cycle.
module coefMulCtrl
  import coefMulPkg::*;
#(
  parameter int COEF_W  = 48,
  parameter int LANES   = 2,
  parameter int GROUP   = 3,
  localparam int SLICE_W = COEF_W / LANES,
  localparam int STEPS   = (SLICE_W + GROUP - 1) / GROUP,
  localparam int LAST    = STEPS + 1,
  localparam int CNT_W   = $clog2(LAST + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  output mulStrobe_t strb,
  output logic       busyOut,
  output logic       validOut
);

  logic             busyQ, validQ;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    strb.load  = start && !busyQ;
    strb.step  = busyQ && (cnt < CNT_W'(STEPS));
    strb.merge = busyQ && (cnt == CNT_W'(STEPS));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      validQ <= 1'b0;
      cnt    <= '0;
    end else if (!busyQ) begin
      if (start) begin
        busyQ <= 1'b1;
        cnt   <= '0;
      end
    end else begin
      cnt <= cnt + CNT_W'(1);
      if (cnt == CNT_W'(STEPS)) validQ <= 1'b1;
      if (cnt == CNT_W'(LAST)) begin
        busyQ  <= 1'b0;
        validQ <= 1'b0;
      end
    end
  end

  assign busyOut  = busyQ;
  assign validOut = validQ;

  // R4: valid only inside the busy window, in its last cycle
  p_valid_in_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    validQ |-> (busyQ && cnt == CNT_W'(LAST)));

  // R5: valid never lasts two cycles
  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    validQ |=> !validQ);

  // R2: busy releases right after its last cycle
  p_busy_release_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && cnt == CNT_W'(LAST)) |=> !busyQ);

  // R6: a start during busy does not restart the count
  p_start_ignored_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && start && cnt != CNT_W'(LAST)) |=>
      (busyQ && cnt == $past(cnt) + CNT_W'(1)));

endmodule

// File: rtl/coefMul.sv
module coefMul
  import coefMulPkg::*;
#(
  parameter int COEF_W = 48,
  parameter int LANES  = 2,
  parameter int GROUP  = 3,
  localparam int PROD_W = 2 * COEF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [COEF_W-1:0] coefA,
  input  logic [COEF_W-1:0] coefB,
  output logic              busy,
  output logic              resultValid,
  output logic [PROD_W-1:0] product
);

  mulStrobe_t strb;

  coefMulCtrl #(
    .COEF_W(COEF_W),
    .LANES (LANES),
    .GROUP (GROUP)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .strb    (strb),
    .busyOut (busy),
    .validOut(resultValid)
  );

  coefMulDatapath #(
    .COEF_W(COEF_W),
    .LANES (LANES),
    .GROUP (GROUP)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .coefA     (coefA),
    .coefB     (coefB),
    .productOut(product)
  );

endmodule

// File: tb/coefMul_tb.sv
`timescale 1ns/1ps
module coefMul_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [47:0] coefA = '0, coefB = '0;
  logic        busy, resultValid;
  logic [95:0] product;

  int checkCount = 0;
  int failCount  = 0;

  always #4 clk = ~clk;  // 125 MHz

  coefMul u_dut (
    .clk(clk), .rstN(rstN), .start(start), .coefA(coefA), .coefB(coefB),
    .busy(busy), .resultValid(resultValid), .product(product)
  );

  localparam logic [95:0] VECS [12] = '{
    {48'h0,            48'h0},
    {48'hFFFF_FFFF_FFFF, 48'hFFFF_FFFF_FFFF},
    {48'h1,            48'h1},
    {48'h8000_0000_0000, 48'h8000_0000_0000},
    {48'hFFFF_FFFF_FFFF, 48'h0},
    {48'h0,            48'hFFFF_FFFF_FFFF},
    {48'h0000_0100_0000, 48'h0000_0080_0000},
    {48'hA5A5_A5A5_A5A5, 48'h5A5A_5A5A_5A5A},
    {48'h1234_5678_9ABC, 48'hDEF0_1234_5678},
    {48'hFFFF_FFFF_FFFF, 48'h1},
    {48'h8000_0000_0001, 48'hFFFF_FF00_0000},
    {48'hC0FF_EE12_3456, 48'h0000_00FF_FFFF}
  };

  task automatic check(input bit ok, input string req, input logic [95:0] act,
                       input logic [95:0] exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One full operation; optionally pokes a second start while busy (R6)
  task automatic runOp(input logic [47:0] a, input logic [47:0] b, input bit poke);
    logic [95:0] exp;
    logic [95:0] got;
    int firstValid;
    int validCnt;
    bit busyOk;
    exp = {48'b0, a} * {48'b0, b};
    firstValid = -1; validCnt = 0; busyOk = 1'b1; got = '0;
    @(negedge clk);
    coefA = a; coefB = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 10; k++) begin
      if (k > 0) @(negedge clk);
      if (!busy) busyOk = 1'b0;
      if (resultValid) begin
        validCnt++;
        if (firstValid < 0) firstValid = k;
      end
      if (k == 9) got = product;
      if (poke && k == 3) begin
        coefA = ~a; coefB = b ^ 48'h1; start = 1'b1;
      end else begin
        start = 1'b0;
      end
    end
    check(busyOk, "R2 busy for ten cycles", 96'(busyOk), 96'd1);
    check(firstValid == 9, "R4 valid in tenth cycle", 96'(firstValid), 96'd9);
    check(validCnt == 1, "R5 single valid pulse", 96'(validCnt), 96'd1);
    check(got === exp, poke ? "R6 start during busy ignored" : "R3 product", got, exp);
    @(negedge clk);
    check(!busy && !resultValid, "R2 idle after ten cycles",
          96'({busy, resultValid}), 96'd0);
  endtask

  initial begin
    #(200000 * 8);
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    logic [95:0] held;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(!busy && !resultValid && product == '0, "R1 reset state",
          {busy, resultValid, product[93:0]}, 96'd0);

    // R3: table of vectors, each an {a, b} pair
    foreach (VECS[i]) runOp(VECS[i][95:48], VECS[i][47:0], 1'b0);

    // R3: pseudo-random operands
    for (int i = 0; i < 20; i++) begin
      logic [47:0] ra, rb;
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      runOp(ra, rb, 1'b0);
    end

    // R8: multiplier bits only in the upper lane, then only in the lower lane
    runOp(48'hFFFF_FFFF_FFFF, 48'h0000_0100_0000, 1'b0);
    runOp(48'hFFFF_FFFF_FFFF, 48'h0000_0080_0000, 1'b0);
    runOp(48'h9876_5432_10FE, 48'hABCD_EF00_0000, 1'b0);
    check(product == {48'b0, 48'h9876_5432_10FE} * {48'b0, 48'hABCD_EF00_0000},
          "R8 upper lane weight", product,
          {48'b0, 48'h9876_5432_10FE} * {48'b0, 48'hABCD_EF00_0000});
    runOp(48'h9876_5432_10FE, 48'h0000_0000_ABCD, 1'b0);
    check(product == {48'b0, 48'h9876_5432_10FE} * 96'h0000_ABCD,
          "R8 lower lane alone", product,
          {48'b0, 48'h9876_5432_10FE} * 96'h0000_ABCD);

    // R6: a second start mid-operation changes nothing
    runOp(48'h0F0F_0F0F_0F0F, 48'h3333_3333_3333, 1'b1);
    repeat (12) begin
      @(negedge clk);
      check(!busy && !resultValid, "R6 no extra operation after poke",
            96'({busy, resultValid}), 96'd0);
    end

    // R7: product held while idle and through the next operation until its valid
    held = product;
    @(negedge clk);
    coefA = 48'h1; coefB = 48'h2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 9; k++) begin
      if (k > 0) @(negedge clk);
      check(product === held, "R7 product held until next valid", product, held);
    end
    @(negedge clk);
    check(resultValid && product == 96'd2, "R7 new product replaces held one",
          product, 96'd2);
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

endmodule